// File: doc/BRIEF.md
# Sixteen-Bit Timer With Watchdog Mode

A single counter that either keeps time as a general-purpose timer or guards the system as a watchdog. A control register sets the count direction, the enable, the reload behaviour, the clock divider and the watchdog options. A load register supplies the reload value. While the timer runs it steps once per divided clock tick. In periodic mode it reloads when it passes its terminal count, and in free-running mode it wraps. Each terminal pass produces a one-cycle interrupt pulse.

In watchdog mode, software must pulse the refresh input before the count runs out. Each refresh puts the load value back into the counter. If the count does run out, the block sends a one-cycle reset request to the system, or an interrupt pulse if the control register selects that instead. Watchdog mode cannot be turned off by a control write once it is on. Only the block reset clears it. A control bit can also freeze the counter while the peripheral power-down input is high.

Top module: `wdt_timer16`

## Requirements
- R1: After reset, `count_o`, `ctrl_o`, `irq_o` and `wdt_rst_o` are all zero.
- R2: A control write stores bits 8:5 and 3:0 of the write data. Bits 15:9 and bit 4 always read back as 0 on `ctrl_o`. Bit 8 selects the direction (1 = up, 0 = down). Bit 7 is the enable. Bit 6 selects periodic mode (1) or free-running mode (0). Bit 5 selects watchdog mode. Bits 3:2 select the divider. Bit 1 selects an interrupt on watchdog expiry. Bit 0 selects halt during power-down.
- R3: A load write stores the value and copies it into the counter on the same clock edge. A load write takes priority over a refresh and over a tick.
- R4: While bit 7 is 0, the counter holds its value.
- R5: While enabled, each tick decrements the counter when bit 8 is 0 and increments it when bit 8 is 1.
- R6: Divider code 01 gives one tick every 16 enabled clocks, and code 10 gives one tick every 256. Codes 00 and 11 give one tick every clock. The divider restarts on every control write, load write and accepted refresh.
- R7: In periodic mode, a tick at the terminal count (0 when counting down, 0xFFFF when counting up) loads the counter from the load register. `irq_o` is high for the following cycle.
- R8: In free-running mode, a tick at the terminal count wraps the counter (0 to 0xFFFF, or 0xFFFF to 0) and pulses `irq_o`.
- R9: When bit 0 is 1 and `pwr_down_i` is high, the counter and the divider stand still. When bit 0 is 0, counting continues during power-down.
- R10: In watchdog mode with bit 1 = 0, a tick at the terminal count reloads the counter and pulses `wdt_rst_o` for one cycle, while `irq_o` stays low.
- R11: In watchdog mode with bit 1 = 1, expiry pulses `irq_o` instead, and `wdt_rst_o` stays low.
- R12: In watchdog mode, `kick_i` reloads the counter from the load register. A refresh in the same cycle as an expiry wins, and no pulse is produced. Outside watchdog mode, `kick_i` has no effect.
- R13: Once bit 5 is set, control writes cannot clear it. Only `rst_n` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 16 | Control write data |
| load_we_i | input | 1 | Load register write strobe |
| load_wdata_i | input | W | Load write data |
| pwr_down_i | input | 1 | Peripheral power-down indication |
| kick_i | input | 1 | Watchdog refresh |
| ctrl_o | output | 16 | Control register read-back |
| count_o | output | W | Current counter value |
| irq_o | output | 1 | Timeout or watchdog interrupt pulse |
| wdt_rst_o | output | 1 | Watchdog reset request pulse |

## Verification
Refresh and expiry can fall in the same cycle. The bench lets the watchdog run down to zero and then raises `kick_i` during the cycle whose edge would expire it. It then checks that the counter holds the load value and that neither `wdt_rst_o` nor `irq_o` pulses. A second collision is a control write landing on a counting edge. For this case, the lock check confirms that the watchdog bit survives a clearing write while counting goes on under the old settings.

// File: rtl/wdt_timer16.sv
module wdt_timer16 #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctrl_we_i,
  input  logic [15:0]  ctrl_wdata_i,
  input  logic         load_we_i,
  input  logic [W-1:0] load_wdata_i,
  input  logic         pwr_down_i,
  input  logic         kick_i,
  output logic [15:0]  ctrl_o,
  output logic [W-1:0] count_o,
  output logic         irq_o,
  output logic         wdt_rst_o
);
  localparam logic [15:0] CTRL_MASK = 16'h01EF;
  localparam logic [15:0] WD_BIT    = 16'h0020;

  logic [15:0]  ctrl_q;
  logic [W-1:0] load_q, cnt_q;
  logic [7:0]   pre_q;
  logic         irq_q, rst_q;

  wire up_dir  = ctrl_q[8];
  wire enable  = ctrl_q[7];
  wire reload  = ctrl_q[6] | ctrl_q[5];
  wire wd_mode = ctrl_q[5];
  wire wd_irq  = ctrl_q[1];
  wire run     = enable & ~(ctrl_q[0] & pwr_down_i);

  logic pre_hit;
  always_comb begin
    case (ctrl_q[3:2])
      2'b01:   pre_hit = (pre_q[3:0] == 4'hF);
      2'b10:   pre_hit = (pre_q == 8'hFF);
      default: pre_hit = 1'b1;
    endcase
  end

  wire tick     = run & pre_hit;
  wire at_end   = up_dir ? (cnt_q == {W{1'b1}}) : (cnt_q == {W{1'b0}});
  wire kick_ok  = kick_i & wd_mode;
  wire restart  = ctrl_we_i | load_we_i | kick_ok;
  wire expire   = tick & at_end & ~load_we_i & ~kick_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= '0;
    end else begin
      if (ctrl_we_i) ctrl_q <= (ctrl_wdata_i & CTRL_MASK) | (ctrl_q & WD_BIT);
      if (load_we_i) load_q <= load_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_q <= '0;
    else if (restart) pre_q <= '0;
    else if (run)     pre_q <= pre_q + 8'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (load_we_i)         cnt_q <= load_wdata_i;
    else if (kick_ok)           cnt_q <= load_q;
    else if (tick) begin
      if (at_end && reload)     cnt_q <= load_q;
      else if (up_dir)          cnt_q <= cnt_q + W'(1);
      else                      cnt_q <= cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      irq_q <= expire & (~wd_mode | wd_irq);
      rst_q <= expire & wd_mode & ~wd_irq;
    end
  end

  assign ctrl_o    = ctrl_q;
  assign count_o   = cnt_q;
  assign irq_o     = irq_q;
  assign wdt_rst_o = rst_q;

  a_r13_wd_lock: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[5] |=> ctrl_q[5]);

  a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_q && rst_q));

  a_r10_rst_source: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |-> $past(ctrl_q[5] && !ctrl_q[1]));

  a_r4_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[7] && !load_we_i && !(kick_i && ctrl_q[5])) |=> $stable(cnt_q));

  a_r3_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
    load_we_i |=> cnt_q == $past(load_wdata_i));

  a_r12_kick_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_i && ctrl_q[5] && !load_we_i) |=> (cnt_q == $past(load_q)) && !rst_q && !irq_q);
endmodule

// File: tb/test_wdt_timer16.sv
module test_wdt_timer16;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0, load_we = 1'b0, pwr_down = 1'b0, kick = 1'b0;
  logic [15:0] ctrl_wdata = '0, load_wdata = '0;
  logic [15:0] ctrl_o, count_o;
  logic        irq_o, wdt_rst_o;
  int          n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  wdt_timer16 i_wdt_timer16 (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
    .load_we_i(load_we), .load_wdata_i(load_wdata),
    .pwr_down_i(pwr_down), .kick_i(kick),
    .ctrl_o(ctrl_o), .count_o(count_o), .irq_o(irq_o), .wdt_rst_o(wdt_rst_o)
  );

  // {ctrl, load, cycles, pwr_down, expected count, requirement}
  localparam int NV = 12;
  localparam logic [72:0] VEC [NV] = '{
    {16'h0080, 16'h0010, 16'd5,   1'b0, 16'h000B, 8'd5},  // R5 down
    {16'h0180, 16'h0010, 16'd5,   1'b0, 16'h0015, 8'd5},  // R5 up
    {16'h0084, 16'h0100, 16'd48,  1'b0, 16'h00FD, 8'd6},  // R6 divide 16
    {16'h0188, 16'h0000, 16'd512, 1'b0, 16'h0002, 8'd6},  // R6 divide 256
    {16'h008C, 16'h0020, 16'd7,   1'b0, 16'h0019, 8'd6},  // R6 code 11
    {16'h0080, 16'h0002, 16'd4,   1'b0, 16'hFFFE, 8'd8},  // R8 wrap down
    {16'h0180, 16'hFFFE, 16'd3,   1'b0, 16'h0001, 8'd8},  // R8 wrap up
    {16'h00C0, 16'h0003, 16'd6,   1'b0, 16'h0001, 8'd7},  // R7 reload down
    {16'h01C0, 16'hFFFD, 16'd5,   1'b0, 16'hFFFF, 8'd7},  // R7 reload up
    {16'h0000, 16'h1234, 16'd10,  1'b0, 16'h1234, 8'd4},  // R4 disabled
    {16'h0081, 16'h0050, 16'd10,  1'b1, 16'h0050, 8'd9},  // R9 halted
    {16'h0080, 16'h0050, 16'd10,  1'b1, 16'h0046, 8'd9}   // R9 runs on
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [15:0] v);
    ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic wr_load(input logic [15:0] v);
    load_we = 1'b1; load_wdata = v;
    @(negedge clk);
    load_we = 1'b0;
  endtask

  task automatic pulse_kick();
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wait_n(2);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #1500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    check("R1 count", count_o, 16'h0000);
    check("R1 ctrl", ctrl_o, 16'h0000);
    check("R1 irq/rst", {14'd0, irq_o, wdt_rst_o}, 16'h0000);

    for (int v = 0; v < NV; v++) begin
      wr_ctrl(16'h0000);
      wr_load(VEC[v][56:41]);
      pwr_down = VEC[v][24];
      wr_ctrl(VEC[v][72:57]);
      wait_n(int'(VEC[v][40:25]));
      check($sformatf("R%0d vector %0d", VEC[v][7:0], v), count_o, VEC[v][23:8]);
      pwr_down = 1'b0;
    end

    // R2 reserved bits read as zero
    wr_ctrl(16'hFEDF);
    check("R2 ctrl readback", ctrl_o, 16'h00CF);

    // R3 load copies into counter
    wr_ctrl(16'h0000);
    wr_load(16'hBEEF);
    check("R3 load", count_o, 16'hBEEF);

    // R7 timeout pulse in periodic mode
    wr_load(16'h0002);
    wr_ctrl(16'h00C0);
    wait_n(2);
    check("R7 irq before end", {15'd0, irq_o}, 16'h0000);
    wait_n(1);
    check("R7 irq at reload", {15'd0, irq_o}, 16'h0001);
    check("R7 reloaded", count_o, 16'h0002);
    wait_n(1);
    check("R7 irq one cycle", {15'd0, irq_o}, 16'h0000);

    // R8 pulse on free-running wrap
    wr_ctrl(16'h0000);
    wr_load(16'h0001);
    wr_ctrl(16'h0080);
    wait_n(2);
    check("R8 wrap irq", {15'd0, irq_o}, 16'h0001);
    check("R8 wrap value", count_o, 16'hFFFF);

    // R12 kick ignored outside watchdog mode
    wr_ctrl(16'h0000);
    wr_load(16'h0005);
    wr_ctrl(16'h0080);
    pulse_kick();
    check("R12 kick ignored", count_o, 16'h0004);

    // R10 watchdog expiry requests reset
    wr_ctrl(16'h0000);
    wr_load(16'h0003);
    wr_ctrl(16'h00A0);
    wait_n(3);
    check("R10 at zero", count_o, 16'h0000);
    check("R10 no early rst", {15'd0, wdt_rst_o}, 16'h0000);
    wait_n(1);
    check("R10 rst pulse", {15'd0, wdt_rst_o}, 16'h0001);
    check("R10 no irq", {15'd0, irq_o}, 16'h0000);
    check("R10 reload", count_o, 16'h0003);
    wait_n(1);
    check("R10 rst one cycle", {15'd0, wdt_rst_o}, 16'h0000);

    // R13 watchdog bit cannot be cleared
    wr_ctrl(16'h0080);
    check("R13 lock", ctrl_o, 16'h00A0);

    // R12 refresh reloads, and wins against expiry
    pulse_kick();
    check("R12 kick reload", count_o, 16'h0003);
    wait_n(3);
    check("R12 at zero", count_o, 16'h0000);
    pulse_kick();
    check("R12 kick vs expiry count", count_o, 16'h0003);
    check("R12 kick vs expiry pulses", {14'd0, irq_o, wdt_rst_o}, 16'h0000);

    // R11 interrupt instead of reset
    wr_ctrl(16'h00A2);
    wait_n(2);
    check("R11 at zero", count_o, 16'h0000);
    wait_n(1);
    check("R11 irq/rst", {14'd0, irq_o, wdt_rst_o}, 16'h0002);

    // R13 only reset clears the watchdog bit
    do_reset();
    check("R13 cleared by reset", ctrl_o, 16'h0000);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule